// File: doc/BRIEF.md
# Record Transfer and Validation Engine

This engine carries out the two data-moving commands of an error-record store: writing a record from an exchange buffer into a storage slot, and reading a stored record back into the exchange buffer. Before it moves anything it checks the record's own header. Two fields matter. The length is a little-endian 32-bit value at byte 20 of the record, so it sits in bits 63:32 of 64-bit word 2. The identifier is a little-endian 64-bit value at byte 96, which is the whole of word 12. A command front-end starts an operation with a one-cycle pulse. It receives a status code and an updated pending identifier in the single cycle that `done` is high.

Slot bookkeeping lives outside the engine, in a slot map manager. The engine asks it to look up an identifier, to name the first stored record, or to name the first free slot. When a write succeeds, the engine gives it a one-cycle update. The map request channel is valid/ready. Once `map_req_valid` is high it stays high, with operation and identifier held stable, until a cycle in which `map_req_ready` is also high. The manager answers with a single `map_rsp_valid` cycle at any later time, and the engine has no back-pressure on that answer.

Both memories are synchronous RAMs with 64-bit words and one cycle of read latency. The exchange buffer port has byte enables. The storage address is the slot index concatenated with the word index, because a slot is exactly `REC_BYTES` long and `REC_BYTES` is a power of two. Copies move one word per cycle.

Top module: `rec_xfer_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, `done` is low and the engine issues no memory write and no map request. `done` is a single-cycle pulse.
- R2: A write whose byte offset is not a multiple of 8, whose offset exceeds `REC_BYTES`-128, whose header length is below 128, or whose offset plus length exceeds `REC_BYTES` finishes with status 3. It makes no storage write and no map update.
- R3: A write whose header identifier is all zeros or all ones finishes with status 3 and leaves the map untouched.
- R4: A write whose identifier the map already holds overwrites that slot. It reports status 0 and raises a map update with `map_upd_new` = 0.
- R5: A write of an identifier the map does not hold asks for the first free slot (map op 2). On success it reports status 0 and raises a map update for that slot with `map_upd_new` = 1.
- R6: A write that finds no free slot finishes with status 1 and makes no storage write.
- R7: After a successful write, byte p of the slot equals record byte p for p below the length, and equals 0xFF from the length up to the end of the slot.
- R8: A read while `rec_count` is zero finishes with status 4 and writes nothing to the exchange buffer.
- R9: A read with pending identifier 0 first asks the map for the first stored record (map op 1) and uses its identifier. A read whose identifier is all ones finishes with status 3.
- R10: A read of an identifier the map does not hold (map op 0 misses) finishes with status 5.
- R11: A successful read writes exactly the stored length of bytes to the exchange buffer, starting at the offset, and leaves every other byte untouched. Reads obey the offset and length limits of R2 and report status 3 without any exchange write.
- R12: After a successful read, `next_id` is the identifier of the first stored record. A failed read reports the identifier it used. A write reports `pend_id` unchanged.
- R13: While a map request is stalled, `map_req_valid`, `map_req_op` and `map_req_id` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command pulse, taken while idle |
| op_read | input | 1 | 1 selects read, 0 selects write |
| rec_offset | input | 32 | Byte offset of the record inside the exchange buffer |
| pend_id | input | 64 | Pending record identifier from the front-end |
| rec_count | input | 32 | Number of stored records |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 no space, 3 failed, 4 store empty, 5 not found |
| next_id | output | 64 | Pending identifier to keep, valid with `done` |
| map_req_valid | output | 1 | Map request valid |
| map_req_ready | input | 1 | Map request accepted |
| map_req_op | output | 2 | 0 look up identifier, 1 first stored record, 2 first free slot |
| map_req_id | output | 64 | Identifier for a lookup |
| map_rsp_valid | input | 1 | Map answer valid |
| map_rsp_hit | input | 1 | Entry found |
| map_rsp_index | input | SLOT_IDX_W | Slot index found |
| map_rsp_id | input | 64 | Identifier found (first-stored query) |
| map_upd_valid | output | 1 | Record a written identifier in the map |
| map_upd_index | output | SLOT_IDX_W | Slot to update |
| map_upd_id | output | 64 | Identifier to store |
| map_upd_new | output | 1 | Slot was free before, so the count rises |
| xb_rd_en | output | 1 | Exchange buffer read |
| xb_wr_en | output | 1 | Exchange buffer write |
| xb_addr | output | log2(REC_BYTES/8) | Exchange buffer word address |
| xb_wdata | output | 64 | Exchange buffer write data |
| xb_be | output | 8 | Exchange buffer byte enables |
| xb_rdata | input | 64 | Exchange buffer read data, one cycle after `xb_rd_en` |
| st_rd_en | output | 1 | Storage read |
| st_wr_en | output | 1 | Storage write, all bytes |
| st_addr | output | SLOT_IDX_W+log2(REC_BYTES/8) | Storage word address {slot, word} |
| st_wdata | output | 64 | Storage write data |
| st_rdata | input | 64 | Storage read data, one cycle after `st_rd_en` |

## Verification
The finishing cycle of an operation depends on the map manager's stalls and on the record length. A write that is accepted spends one cycle per word of the whole slot before `done`. A read spends one cycle per word of the stored length. The bench therefore does not count to a fixed latency. It raises `start` for one cycle and then samples at each falling edge until `done` is high, with a per-operation bound. It reads `status` and `next_id` in that same half-cycle. The map update and the memory write counters settle at the next rising edge, so the bench waits one more falling edge before it compares them and the RAM contents.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

  // header field positions in 64-bit words (length lives in bits 63:32 of word 2)
  localparam int unsigned LEN_FIELD_WORD = 2;
  localparam int unsigned ID_FIELD_WORD  = 12;
  localparam int unsigned MIN_REC_BYTES  = 128;

  typedef enum logic [2:0] {
    RXE_OK       = 3'd0,
    RXE_NO_SPACE = 3'd1,
    RXE_FAILED   = 3'd3,
    RXE_EMPTY    = 3'd4,
    RXE_MISSING  = 3'd5
  } rxe_status_e;

  typedef enum logic [1:0] {
    MAP_LOOKUP = 2'd0,
    MAP_FIRST  = 2'd1,
    MAP_ALLOC  = 2'd2
  } rxe_map_op_e;

  typedef enum logic [2:0] {
    PH_WLOOK,
    PH_WALLOC,
    PH_SUBST,
    PH_RLOOK,
    PH_RFINAL
  } rxe_phase_e;

  function automatic logic id_usable(input logic [63:0] id);
    return (id != 64'd0) && (id != '1);
  endfunction

endpackage

// File: rtl/rxe_hdr_check.sv
module rxe_hdr_check
  import rxe_pkg::*;
#(
  parameter int unsigned REC_BYTES = 4096
) (
  input  logic [31:0] ofs,
  input  logic [31:0] len,
  output logic        ofs_bad,
  output logic        len_bad
);

  localparam logic [32:0] SPAN    = 33'(REC_BYTES);
  localparam logic [32:0] OFS_MAX = 33'(REC_BYTES - MIN_REC_BYTES);

  logic [32:0] ofs_ext;
  logic [32:0] end_pos;

  always_comb begin
    ofs_ext = {1'b0, ofs};
    end_pos = ofs_ext + {1'b0, len};
    ofs_bad = (ofs[2:0] != 3'd0) || (ofs_ext > OFS_MAX);
    len_bad = (len < 32'(MIN_REC_BYTES)) || (end_pos > SPAN);
  end

endmodule

// File: rtl/rxe_copy.sv
module rxe_copy #(
  parameter int unsigned WORDS = 512,
  parameter int unsigned WA_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            pad_tail,
  input  logic [31:0]     len,
  output logic            src_en,
  output logic [WA_W-1:0] src_idx,
  input  logic [63:0]     src_data,
  output logic            dst_en,
  output logic [WA_W-1:0] dst_idx,
  output logic [63:0]     dst_data,
  output logic [7:0]      dst_be,
  output logic            fin
);

  localparam int unsigned CW = WA_W + 1;

  logic            active;
  logic [CW-1:0]   rd_idx;
  logic [CW-1:0]   total_q;
  logic [CW-1:0]   ndata_q;
  logic [CW-1:0]   ndata_w;
  logic            pad_q;
  logic [31:0]     len_q;
  logic            p_v;
  logic            p_rd;
  logic [WA_W-1:0] p_idx;
  logic [31:0]     p_base;

  always_comb begin
    ndata_w = CW'((len + 32'd7) >> 3);
    src_en  = active && (rd_idx < ndata_q);
    src_idx = rd_idx[WA_W-1:0];
    dst_en  = p_v;
    dst_idx = p_idx;
    fin     = p_v && ({1'b0, p_idx} == (total_q - CW'(1)));
    p_base  = {{(32-WA_W-3){1'b0}}, p_idx, 3'b000};
  end

  // one lane per byte: data below the length, 0xFF filler above it
  for (genvar gb = 0; gb < 8; gb++) begin : g_lane
    logic in_rec;
    always_comb begin
      in_rec = (p_base + 32'(gb)) < len_q;
      dst_data[8*gb +: 8] = (p_rd && in_rec) ? src_data[8*gb +: 8] : 8'hFF;
      dst_be[gb] = pad_q || in_rec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_idx  <= '0;
      total_q <= '0;
      ndata_q <= '0;
      pad_q   <= 1'b0;
      len_q   <= '0;
      p_v     <= 1'b0;
      p_rd    <= 1'b0;
      p_idx   <= '0;
    end else begin
      if (go) begin
        active  <= 1'b1;
        rd_idx  <= '0;
        pad_q   <= pad_tail;
        len_q   <= len;
        ndata_q <= ndata_w;
        total_q <= pad_tail ? CW'(WORDS) : ndata_w;
      end else if (active) begin
        rd_idx <= rd_idx + CW'(1);
        if (rd_idx == (total_q - CW'(1))) active <= 1'b0;
      end
      p_v   <= active;
      p_rd  <= src_en;
      p_idx <= rd_idx[WA_W-1:0];
    end
  end

endmodule

// File: rtl/rec_xfer_engine.sv
module rec_xfer_engine
  import rxe_pkg::*;
#(
  parameter int unsigned REC_BYTES  = 4096,
  parameter int unsigned SLOT_IDX_W = 2,
  localparam int unsigned WORDS     = REC_BYTES / 8,
  localparam int unsigned WA_W      = $clog2(WORDS),
  localparam int unsigned SA_W      = SLOT_IDX_W + WA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  op_read,
  input  logic [31:0]           rec_offset,
  input  logic [63:0]           pend_id,
  input  logic [31:0]           rec_count,
  output logic                  busy,
  output logic                  done,
  output logic [2:0]            status,
  output logic [63:0]           next_id,
  output logic                  map_req_valid,
  input  logic                  map_req_ready,
  output logic [1:0]            map_req_op,
  output logic [63:0]           map_req_id,
  input  logic                  map_rsp_valid,
  input  logic                  map_rsp_hit,
  input  logic [SLOT_IDX_W-1:0] map_rsp_index,
  input  logic [63:0]           map_rsp_id,
  output logic                  map_upd_valid,
  output logic [SLOT_IDX_W-1:0] map_upd_index,
  output logic [63:0]           map_upd_id,
  output logic                  map_upd_new,
  output logic                  xb_rd_en,
  output logic                  xb_wr_en,
  output logic [WA_W-1:0]       xb_addr,
  output logic [63:0]           xb_wdata,
  output logic [7:0]            xb_be,
  input  logic [63:0]           xb_rdata,
  output logic                  st_rd_en,
  output logic                  st_wr_en,
  output logic [SA_W-1:0]       st_addr,
  output logic [63:0]           st_wdata,
  input  logic [63:0]           st_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_WLEN, S_WID, S_WIDCAP, S_RCHK, S_MAPREQ, S_MAPRSP,
    S_RLEN, S_RLENCAP, S_RLENCHK, S_COPY, S_DONE
  } state_e;

  state_e                state;
  logic                  op_q;
  logic [31:0]           ofs_q;
  logic [31:0]           len_q;
  logic [63:0]           id_q;
  logic [63:0]           pend_q;
  logic [SLOT_IDX_W-1:0] slot_q;
  rxe_status_e           stat_q;
  rxe_map_op_e           mop_q;
  rxe_phase_e            phase_q;
  logic                  upd_q;
  logic                  new_q;
  logic                  cp_go_q;

  logic                  ofs_bad;
  logic                  len_bad;
  logic [WA_W-1:0]       off_w;

  logic                  cp_src_en;
  logic [WA_W-1:0]       cp_src_idx;
  logic [63:0]           cp_src_data;
  logic                  cp_dst_en;
  logic [WA_W-1:0]       cp_dst_idx;
  logic [63:0]           cp_dst_data;
  logic [7:0]            cp_dst_be;
  logic                  cp_fin;

  rxe_hdr_check #(.REC_BYTES(REC_BYTES)) u_hdr (
    .ofs     (ofs_q),
    .len     (len_q),
    .ofs_bad (ofs_bad),
    .len_bad (len_bad)
  );

  rxe_copy #(.WORDS(WORDS), .WA_W(WA_W)) u_copy (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (cp_go_q),
    .pad_tail (!op_q),
    .len      (len_q),
    .src_en   (cp_src_en),
    .src_idx  (cp_src_idx),
    .src_data (cp_src_data),
    .dst_en   (cp_dst_en),
    .dst_idx  (cp_dst_idx),
    .dst_data (cp_dst_data),
    .dst_be   (cp_dst_be),
    .fin      (cp_fin)
  );

  // ---------------- datapath muxing ----------------
  always_comb begin
    off_w       = ofs_q[WA_W+2:3];
    cp_src_data = op_q ? st_rdata : xb_rdata;

    xb_rd_en = (state == S_WLEN) || (state == S_WID) || (cp_src_en && !op_q);
    if (state == S_WLEN)      xb_addr = off_w + WA_W'(LEN_FIELD_WORD);
    else if (state == S_WID)  xb_addr = off_w + WA_W'(ID_FIELD_WORD);
    else if (op_q)            xb_addr = off_w + cp_dst_idx;
    else                      xb_addr = off_w + cp_src_idx;
    xb_wr_en = op_q && cp_dst_en;
    xb_wdata = cp_dst_data;
    xb_be    = cp_dst_be;

    st_rd_en = (state == S_RLEN) || (cp_src_en && op_q);
    st_wr_en = !op_q && cp_dst_en;
    st_wdata = cp_dst_data;
    if (state == S_RLEN) st_addr = {slot_q, WA_W'(LEN_FIELD_WORD)};
    else if (op_q)       st_addr = {slot_q, cp_src_idx};
    else                 st_addr = {slot_q, cp_dst_idx};

    busy          = (state != S_IDLE);
    done          = (state == S_DONE);
    status        = stat_q;
    next_id       = op_q ? id_q : pend_q;
    map_req_valid = (state == S_MAPREQ);
    map_req_op    = mop_q;
    map_req_id    = id_q;
    map_upd_valid = (state == S_DONE) && upd_q;
    map_upd_index = slot_q;
    map_upd_id    = id_q;
    map_upd_new   = new_q;
  end

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= 1'b0;
      ofs_q   <= '0;
      len_q   <= '0;
      id_q    <= '0;
      pend_q  <= '0;
      slot_q  <= '0;
      stat_q  <= RXE_OK;
      mop_q   <= MAP_LOOKUP;
      phase_q <= PH_WLOOK;
      upd_q   <= 1'b0;
      new_q   <= 1'b0;
      cp_go_q <= 1'b0;
    end else begin
      cp_go_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            op_q   <= op_read;
            ofs_q  <= rec_offset;
            id_q   <= pend_id;
            pend_q <= pend_id;
            upd_q  <= 1'b0;
            new_q  <= 1'b0;
            state  <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!op_q) begin
            if (ofs_bad) begin
              stat_q <= RXE_FAILED;
              state  <= S_DONE;
            end else begin
              state <= S_WLEN;
            end
          end else if (rec_count == 32'd0) begin
            stat_q <= RXE_EMPTY;
            state  <= S_DONE;
          end else if (id_q == 64'd0) begin
            mop_q   <= MAP_FIRST;
            phase_q <= PH_SUBST;
            state   <= S_MAPREQ;
          end else begin
            state <= S_RCHK;
          end
        end
        S_WLEN: state <= S_WID;
        S_WID: begin
          len_q <= xb_rdata[63:32];
          state <= S_WIDCAP;
        end
        S_WIDCAP: begin
          if (len_bad || !id_usable(xb_rdata)) begin
            stat_q <= RXE_FAILED;
            state  <= S_DONE;
          end else begin
            id_q    <= xb_rdata;
            mop_q   <= MAP_LOOKUP;
            phase_q <= PH_WLOOK;
            state   <= S_MAPREQ;
          end
        end
        S_RCHK: begin
          if ((id_q == '1) || ofs_bad) begin
            stat_q <= RXE_FAILED;
            state  <= S_DONE;
          end else begin
            mop_q   <= MAP_LOOKUP;
            phase_q <= PH_RLOOK;
            state   <= S_MAPREQ;
          end
        end
        S_MAPREQ: if (map_req_ready) state <= S_MAPRSP;
        S_MAPRSP: begin
          if (map_rsp_valid) begin
            unique case (phase_q)
              PH_WLOOK: begin
                if (map_rsp_hit) begin
                  slot_q  <= map_rsp_index;
                  new_q   <= 1'b0;
                  cp_go_q <= 1'b1;
                  state   <= S_COPY;
                end else begin
                  mop_q   <= MAP_ALLOC;
                  phase_q <= PH_WALLOC;
                  state   <= S_MAPREQ;
                end
              end
              PH_WALLOC: begin
                if (map_rsp_hit) begin
                  slot_q  <= map_rsp_index;
                  new_q   <= 1'b1;
                  cp_go_q <= 1'b1;
                  state   <= S_COPY;
                end else begin
                  stat_q <= RXE_NO_SPACE;
                  state  <= S_DONE;
                end
              end
              PH_SUBST: begin
                id_q  <= map_rsp_hit ? map_rsp_id : '1;
                state <= S_RCHK;
              end
              PH_RLOOK: begin
                if (map_rsp_hit) begin
                  slot_q <= map_rsp_index;
                  state  <= S_RLEN;
                end else begin
                  stat_q <= RXE_MISSING;
                  state  <= S_DONE;
                end
              end
              default: begin
                id_q   <= map_rsp_hit ? map_rsp_id : '1;
                stat_q <= RXE_OK;
                state  <= S_DONE;
              end
            endcase
          end
        end
        S_RLEN: state <= S_RLENCAP;
        S_RLENCAP: begin
          len_q <= st_rdata[63:32];
          state <= S_RLENCHK;
        end
        S_RLENCHK: begin
          if (len_bad) begin
            stat_q <= RXE_FAILED;
            state  <= S_DONE;
          end else begin
            cp_go_q <= 1'b1;
            state   <= S_COPY;
          end
        end
        S_COPY: begin
          if (cp_fin) begin
            if (op_q) begin
              mop_q   <= MAP_FIRST;
              phase_q <= PH_RFINAL;
              state   <= S_MAPREQ;
            end else begin
              upd_q  <= 1'b1;
              stat_q <= RXE_OK;
              state  <= S_DONE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxe_checker.sv
module rxe_checker #(
  parameter int unsigned SLOT_IDX_W = 2,
  parameter int unsigned SA_W       = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [2:0]      status,
  input logic            map_req_valid,
  input logic            map_req_ready,
  input logic [1:0]      map_req_op,
  input logic [63:0]     map_req_id,
  input logic            map_upd_valid,
  input logic            xb_wr_en,
  input logic            st_wr_en,
  input logic [SA_W-1:0] st_addr
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!st_wr_en && !xb_wr_en && !map_req_valid && !done));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (map_req_valid && !map_req_ready) |=>
      (map_req_valid && $stable(map_req_id) && $stable(map_req_op)));

  a_r5_upd_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
    map_upd_valid |-> (done && (status == 3'd0)));

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_wr_en && xb_wr_en));

  a_r7_slot_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && $past(st_wr_en)) |->
      (st_addr[SA_W-1 -: SLOT_IDX_W] == $past(st_addr[SA_W-1 -: SLOT_IDX_W])));

endmodule

bind rec_xfer_engine rxe_checker #(.SLOT_IDX_W(SLOT_IDX_W), .SA_W(SA_W)) i_rxe_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .status        (status),
  .map_req_valid (map_req_valid),
  .map_req_ready (map_req_ready),
  .map_req_op    (map_req_op),
  .map_req_id    (map_req_id),
  .map_upd_valid (map_upd_valid),
  .xb_wr_en      (xb_wr_en),
  .st_wr_en      (st_wr_en),
  .st_addr       (st_addr)
);

// File: tb/test_rec_xfer_engine.sv
module test_rec_xfer_engine;

  localparam int REC   = 4096;
  localparam int SIW   = 2;
  localparam int SLOTS = 1 << SIW;
  localparam int WORDS = REC / 8;
  localparam int WA    = $clog2(WORDS);
  localparam int SA    = SIW + WA;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            start = 1'b0, op_read = 1'b0;
  logic [31:0]     rec_offset = '0;
  logic [63:0]     pend_id = '0;
  logic [31:0]     rec_count;
  logic            busy, done;
  logic [2:0]      status;
  logic [63:0]     next_id;
  logic            map_req_valid, map_req_ready;
  logic [1:0]      map_req_op;
  logic [63:0]     map_req_id;
  logic            map_rsp_valid, map_rsp_hit;
  logic [SIW-1:0]  map_rsp_index;
  logic [63:0]     map_rsp_id;
  logic            map_upd_valid, map_upd_new;
  logic [SIW-1:0]  map_upd_index;
  logic [63:0]     map_upd_id;
  logic            xb_rd_en, xb_wr_en, st_rd_en, st_wr_en;
  logic [WA-1:0]   xb_addr;
  logic [63:0]     xb_wdata, xb_rdata, st_wdata, st_rdata;
  logic [7:0]      xb_be;
  logic [SA-1:0]   st_addr;

  rec_xfer_engine #(.REC_BYTES(REC), .SLOT_IDX_W(SIW)) i_rec_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_read(op_read),
    .rec_offset(rec_offset), .pend_id(pend_id), .rec_count(rec_count),
    .busy(busy), .done(done), .status(status), .next_id(next_id),
    .map_req_valid(map_req_valid), .map_req_ready(map_req_ready),
    .map_req_op(map_req_op), .map_req_id(map_req_id),
    .map_rsp_valid(map_rsp_valid), .map_rsp_hit(map_rsp_hit),
    .map_rsp_index(map_rsp_index), .map_rsp_id(map_rsp_id),
    .map_upd_valid(map_upd_valid), .map_upd_index(map_upd_index),
    .map_upd_id(map_upd_id), .map_upd_new(map_upd_new),
    .xb_rd_en(xb_rd_en), .xb_wr_en(xb_wr_en), .xb_addr(xb_addr),
    .xb_wdata(xb_wdata), .xb_be(xb_be), .xb_rdata(xb_rdata),
    .st_rd_en(st_rd_en), .st_wr_en(st_wr_en), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  // ---------------- memory models ----------------
  logic [63:0] xb_mem [0:WORDS-1];
  logic [63:0] st_mem [0:SLOTS*WORDS-1];
  logic        tb_xb_we = 1'b0;
  logic [WA-1:0] tb_xb_addr = '0;
  logic [63:0] tb_xb_data = '0;
  int st_wr_cnt = 0, xb_wr_cnt = 0, upd_cnt = 0, hold_viol = 0, stall_cnt = 0;
  logic last_new = 1'b0;
  logic [SIW-1:0] last_idx = '0;

  always @(posedge clk) begin
    if (xb_rd_en) xb_rdata <= xb_mem[xb_addr];
    if (xb_wr_en) begin
      xb_wr_cnt <= xb_wr_cnt + 1;
      for (int b = 0; b < 8; b++)
        if (xb_be[b]) xb_mem[xb_addr][8*b +: 8] <= xb_wdata[8*b +: 8];
    end else if (tb_xb_we) xb_mem[tb_xb_addr] <= tb_xb_data;
    if (st_rd_en) st_rdata <= st_mem[st_addr];
    if (st_wr_en) begin
      st_mem[st_addr] <= st_wdata;
      st_wr_cnt <= st_wr_cnt + 1;
    end
  end

  // ---------------- slot map manager model (slot 0 reserved) ----------------
  logic [63:0] map_ids [0:SLOTS-1];
  logic ready_t, prev_stall;
  logic [63:0] prev_id;
  logic [1:0] prev_op;
  assign map_req_ready = ready_t;

  always_comb begin
    rec_count = 0;
    for (int i = 1; i < SLOTS; i++) if (map_ids[i] != 0) rec_count = rec_count + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ready_t <= 1'b0; map_rsp_valid <= 1'b0; map_rsp_hit <= 1'b0;
      map_rsp_index <= '0; map_rsp_id <= '0; prev_stall <= 1'b0;
      prev_id <= '0; prev_op <= '0;
      for (int i = 0; i < SLOTS; i++) map_ids[i] <= '0;
    end else begin
      logic h; logic [SIW-1:0] ix; logic [63:0] fid;
      h = 1'b0; ix = '0; fid = '0;
      for (int i = 1; i < SLOTS; i++) begin
        if (!h) begin
          if ((map_req_op == 2'd0 && map_ids[i] == map_req_id && map_req_id != 0) ||
              (map_req_op == 2'd1 && map_ids[i] != 0) ||
              (map_req_op == 2'd2 && map_ids[i] == 0)) begin
            h = 1'b1; ix = SIW'(i); fid = map_ids[i];
          end
        end
      end
      ready_t <= ~ready_t;
      map_rsp_valid <= map_req_valid && ready_t;
      if (map_req_valid && ready_t) begin
        map_rsp_hit <= h; map_rsp_index <= ix; map_rsp_id <= fid;
      end
      if (map_upd_valid) begin
        map_ids[map_upd_index] <= map_upd_id;
        upd_cnt <= upd_cnt + 1; last_new <= map_upd_new; last_idx <= map_upd_index;
      end
      if (map_req_valid && !ready_t) stall_cnt <= stall_cnt + 1;
      if (prev_stall && (!map_req_valid || map_req_id != prev_id || map_req_op != prev_op))
        hold_viol <= hold_viol + 1;
      prev_stall <= map_req_valid && !ready_t;
      prev_id <= map_req_id; prev_op <= map_req_op;
    end
  end

  // ---------------- bookkeeping ----------------
  int tests = 0, fails = 0;
  logic [2:0] r_stat;
  logic [63:0] r_next;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rec_word(input logic [7:0] seed, input int w,
                                           input logic [31:0] len, input logic [63:0] id);
    logic [63:0] base;
    base = {seed, 8'(w), 8'(w * 3), seed ^ 8'h5A, 32'h0BAD_F00D ^ 32'(w)};
    if (w == 2) return {len, base[31:0]};
    if (w == 12) return id;
    return base;
  endfunction

  function automatic logic [63:0] sentinel(input int w);
    return {16'hEEEE, 16'(w), 32'h5151_0000 | 32'(w)};
  endfunction

  task automatic load_record(input int ofs, input int len, input logic [63:0] id, input logic [7:0] seed);
    int nw;
    nw = (len + 7) / 8;
    if (nw < 16) nw = 16;
    for (int w = 0; w < nw; w++) begin
      if (ofs / 8 + w < WORDS) begin
        @(negedge clk);
        tb_xb_we = 1'b1; tb_xb_addr = WA'(ofs / 8 + w); tb_xb_data = rec_word(seed, w, 32'(len), id);
      end
    end
    @(negedge clk);
    tb_xb_we = 1'b0;
  endtask

  task automatic fill_sentinel();
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      tb_xb_we = 1'b1; tb_xb_addr = WA'(w); tb_xb_data = sentinel(w);
    end
    @(negedge clk);
    tb_xb_we = 1'b0;
  endtask

  task automatic run_op(input logic rd, input int ofs, input logic [63:0] id, input string tag);
    int n;
    @(negedge clk);
    start = 1'b1; op_read = rd; rec_offset = 32'(ofs); pend_id = id;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check(done, {tag, " done seen"}, 64'(done), 64'd1);
    r_stat = status;
    r_next = next_id;
    @(negedge clk);
  endtask

  task automatic check_slot(input int slot, input int len, input logic [7:0] seed,
                            input logic [63:0] id, input string tag);
    int errs;
    logic [7:0] e, a;
    errs = 0;
    for (int p = 0; p < REC; p++) begin
      e = (p < len) ? rec_word(seed, p / 8, 32'(len), id)[8*(p%8) +: 8] : 8'hFF;
      a = st_mem[slot*WORDS + p/8][8*(p%8) +: 8];
      if (a !== e) errs++;
    end
    check(errs == 0, {tag, " slot bytes"}, 64'(errs), 64'd0);
  endtask

  task automatic check_xb(input int ofs, input int len, input logic [7:0] seed,
                          input logic [63:0] id, input string tag);
    int errs;
    logic [7:0] e, a;
    errs = 0;
    for (int p = 0; p < REC; p++) begin
      if (p >= ofs && p < ofs + len) e = rec_word(seed, (p - ofs) / 8, 32'(len), id)[8*((p-ofs)%8) +: 8];
      else e = sentinel(p / 8)[8*(p%8) +: 8];
      a = xb_mem[p/8][8*(p%8) +: 8];
      if (a !== e) errs++;
    end
    check(errs == 0, {tag, " exchange bytes"}, 64'(errs), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(!busy && !done, "R1 idle after reset", {busy, done}, 64'd0);
    repeat (5) @(negedge clk);
    check(st_wr_cnt == 0 && xb_wr_cnt == 0, "R1 no writes when idle", 64'(st_wr_cnt + xb_wr_cnt), 64'd0);
  endtask

  task automatic t_read_empty();
    int x0;
    x0 = xb_wr_cnt;
    run_op(1'b1, 0, 64'd0, "R8");
    check(r_stat == 3'd4, "R8 empty status", 64'(r_stat), 64'd4);
    check(xb_wr_cnt == x0, "R8 no exchange write", 64'(xb_wr_cnt - x0), 64'd0);
  endtask

  task automatic t_write_new();
    int u0;
    u0 = upd_cnt;
    load_record(0, 200, 64'h1111, 8'h11);
    run_op(1'b0, 0, 64'hABCD, "R5");
    check(r_stat == 3'd0, "R5 status", 64'(r_stat), 64'd0);
    check(upd_cnt == u0 + 1 && last_new && last_idx == 1, "R5 new slot 1",
          {upd_cnt[31:0], 7'd0, last_new, 6'd0, last_idx}, 64'd1);
    check(r_next == 64'hABCD, "R12 write keeps pending id", r_next, 64'hABCD);
    check_slot(1, 200, 8'h11, 64'h1111, "R7 first write");
  endtask

  task automatic t_write_overwrite();
    int u0;
    u0 = upd_cnt;
    load_record(64, 137, 64'h1111, 8'h22);
    run_op(1'b0, 64, 64'd0, "R4");
    check(r_stat == 3'd0, "R4 status", 64'(r_stat), 64'd0);
    check(upd_cnt == u0 + 1 && !last_new && last_idx == 1, "R4 overwrite slot 1",
          {7'd0, last_new, 6'd0, last_idx}, 64'd1);
    check(rec_count == 1, "R4 count unchanged", 64'(rec_count), 64'd1);
    check_slot(1, 137, 8'h22, 64'h1111, "R7 overwrite");
  endtask

  task automatic t_write_bad_hdr();
    int s0, u0;
    s0 = st_wr_cnt; u0 = upd_cnt;
    load_record(0, 100, 64'h5555, 8'h33);
    run_op(1'b0, 0, 64'd0, "R2 short");
    check(r_stat == 3'd3, "R2 length below 128", 64'(r_stat), 64'd3);
    run_op(1'b0, 3, 64'd0, "R2 unaligned");
    check(r_stat == 3'd3, "R2 unaligned offset", 64'(r_stat), 64'd3);
    run_op(1'b0, REC - 120, 64'd0, "R2 high");
    check(r_stat == 3'd3, "R2 offset above limit", 64'(r_stat), 64'd3);
    load_record(REC - 128, 200, 64'h5555, 8'h33);
    run_op(1'b0, REC - 128, 64'd0, "R2 overrun");
    check(r_stat == 3'd3, "R2 offset plus length overrun", 64'(r_stat), 64'd3);
    check(st_wr_cnt == s0 && upd_cnt == u0, "R2 nothing stored",
          64'(st_wr_cnt - s0 + upd_cnt - u0), 64'd0);
  endtask

  task automatic t_write_bad_id();
    int u0;
    u0 = upd_cnt;
    load_record(0, 160, 64'd0, 8'h44);
    run_op(1'b0, 0, 64'd0, "R3 zero");
    check(r_stat == 3'd3, "R3 zero identifier", 64'(r_stat), 64'd3);
    load_record(0, 160, ONES, 8'h44);
    run_op(1'b0, 0, 64'd0, "R3 ones");
    check(r_stat == 3'd3, "R3 all-ones identifier", 64'(r_stat), 64'd3);
    check(upd_cnt == u0, "R3 map untouched", 64'(upd_cnt - u0), 64'd0);
  endtask

  task automatic t_write_full();
    int s0;
    load_record(0, 403, 64'h2222, 8'h55);
    run_op(1'b0, 0, 64'd0, "R5 second");
    check(r_stat == 3'd0 && last_idx == 2 && last_new, "R5 second record in slot 2", 64'(last_idx), 64'd2);
    load_record(0, 128, 64'h3333, 8'h66);
    run_op(1'b0, 0, 64'd0, "R5 third");
    check(r_stat == 3'd0 && last_idx == 3, "R5 third record in slot 3", 64'(last_idx), 64'd3);
    check_slot(2, 403, 8'h55, 64'h2222, "R7 odd length");
    s0 = st_wr_cnt;
    load_record(0, 128, 64'h4444, 8'h77);
    run_op(1'b0, 0, 64'd0, "R6");
    check(r_stat == 3'd1, "R6 no space status", 64'(r_stat), 64'd1);
    check(st_wr_cnt == s0, "R6 no storage write", 64'(st_wr_cnt - s0), 64'd0);
  endtask

  task automatic t_read_first();
    fill_sentinel();
    run_op(1'b1, 0, 64'd0, "R9");
    check(r_stat == 3'd0, "R9 substituted read status", 64'(r_stat), 64'd0);
    check(r_next == 64'h1111, "R12 next id after read", r_next, 64'h1111);
    check_xb(0, 137, 8'h22, 64'h1111, "R11 first record");
  endtask

  task automatic t_read_by_id();
    fill_sentinel();
    run_op(1'b1, 8, 64'h2222, "R11");
    check(r_stat == 3'd0, "R11 read status", 64'(r_stat), 64'd0);
    check(r_next == 64'h1111, "R12 reset to first", r_next, 64'h1111);
    check_xb(8, 403, 8'h55, 64'h2222, "R11 partial last word");
  endtask

  task automatic t_read_errors();
    int x0;
    x0 = xb_wr_cnt;
    run_op(1'b1, 0, 64'h9999, "R10");
    check(r_stat == 3'd5, "R10 missing identifier", 64'(r_stat), 64'd5);
    run_op(1'b1, 0, ONES, "R9 ones");
    check(r_stat == 3'd3, "R9 all-ones identifier", 64'(r_stat), 64'd3);
    run_op(1'b1, REC - 128, 64'h2222, "R11 overrun");
    check(r_stat == 3'd3, "R11 stored length overruns", 64'(r_stat), 64'd3);
    check(r_next == 64'h2222, "R12 failed read keeps id", r_next, 64'h2222);
    check(xb_wr_cnt == x0, "R11 no exchange write on error", 64'(xb_wr_cnt - x0), 64'd0);
  endtask

  task automatic t_handshake();
    check(stall_cnt > 0, "R13 stalls exercised", 64'(stall_cnt), 64'd1);
    check(hold_viol == 0, "R13 request held while stalled", 64'(hold_viol), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_empty();
    t_write_new();
    t_write_overwrite();
    t_write_bad_hdr();
    t_write_bad_id();
    t_write_full();
    t_read_first();
    t_read_by_id();
    t_read_errors();
    t_handshake();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule